// File: doc/BRIEF.md
# Depth-Cascaded FIFO Token Ring

This block builds one deep first-in/first-out buffer out of several small storage slices on a single clock. All slices see the same write strobe, read strobe, write data and reset. Ownership of the write side and of the read side is held by tokens. Exactly one slice holds the write token and accepts pushes. Exactly one slice holds the read token and presents its oldest word. When a slice fills its last location, it passes the write token to the next slice in a ring. When it drains its last location, it passes the read token on in the same way.

Each hand-off is a two-bit link pulse from a slice to its successor. One bit carries the write token and the other carries the read token, so the receiver knows which one it is taking. A selection input, sampled while reset is active, names the slice that starts with both tokens. Every slice has active-low full and empty flags. The wrapper ORs them into composite flags, so a composite flag is asserted only when every slice is in that condition.

Each token is a two-state machine. TOK_IDLE means the token is not held. TOK_HELD means it is held. Reset loads TOK_HELD into the chosen first slice and TOK_IDLE into all the others. The take transition goes from TOK_IDLE to TOK_HELD on an incoming link pulse. The give transition goes from TOK_HELD to TOK_IDLE when the slice emits its own pulse.

Top module: `dx_fifo_chain`

## Requirements
- R1: While reset is asserted and right after it, the composite empty_n is 0, the composite full_n is 1, and no link pulse is present while the strobes are idle.
- R2: Words leave in the order they were accepted, across every slice boundary. rdata shows the oldest stored word whenever empty_n is 1 (show-ahead), and a read removes that word.
- R3: In the cycle in which slice i accepts a write into its last location (index DEPTH-1), link_wr bit i is 1 and every other link_wr bit is 0. The next accepted write goes to location 0 of slice (i+1) mod NSLICE.
- R4: In the cycle in which slice i reads its last location, link_rd bit i is 1 and every other link_rd bit is 0. The next read is taken from location 0 of slice (i+1) mod NSLICE.
- R5: The slice whose index equals first_slice during reset holds both tokens after reset. Its link bits are the first to pulse after DEPTH writes and after DEPTH reads.
- R6: full_n is 0 exactly when NSLICE*DEPTH words are stored. A write attempted while full_n is 0 is dropped and changes neither the flags nor the stored data.
- R7: empty_n is 0 exactly when no word is stored. A read attempted while empty_n is 0 is ignored.
- R8: A write and a read in the same cycle both take effect, including in a cycle where either one causes a token hand-off. The flags and the next output word then match a push followed by a pop.
- R9: At every cycle after reset, exactly one slice holds the write token and exactly one slice holds the read token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all slices |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_slice | input | SELW | Index of the slice that starts with both tokens, held during reset |
| wr_en | input | 1 | Push strobe |
| wdata | input | WIDTH | Word to push |
| rd_en | input | 1 | Pop strobe |
| rdata | output | WIDTH | Oldest stored word (show-ahead) |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |
| link_wr | output | NSLICE | Write-token hand-off pulse from each slice |
| link_rd | output | NSLICE | Read-token hand-off pulse from each slice |

## Verification
A push and a pop can land in the same cycle. Either one may also be the access to a slice's last location, so a token hand-off coincides with the opposite operation. The bench provokes this with a directed sequence: it fills past the first boundary, then issues combined push-and-pop cycles until the write token moves on while a read is under way. Random phases with mixed strobe probabilities also create such cycles near the full and empty ends. In the cycle after such a pair, the flags and the shown word are compared against a queue model under the R8 tag, and the link pulses are compared against slice and location counters the bench keeps itself.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

    // Hand-off pulse from one slice to the next in the ring.
    typedef struct packed {
        logic wr;   // write token moves on
        logic rd;   // read token moves on
    } hop_t;

    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_HELD = 1'b1
    } tok_state_e;

endpackage

// File: rtl/dxc_token.sv
module dxc_token
    import dxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic first_n,   // low: this slice starts with the token
    input  logic take,      // pulse from predecessor
    input  logic give,      // own hand-off pulse
    output logic held
);

    tok_state_e state_q, state_d;

    // State register; reset value chosen by the first-load input.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= first_n ? TOK_IDLE : TOK_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_IDLE: if (take)          state_d = TOK_HELD;
            TOK_HELD: if (give && !take) state_d = TOK_IDLE;
            default:                     state_d = TOK_IDLE;
        endcase
    end

    always_comb held = (state_q == TOK_HELD);

    // R3 and R4: giving the token away leaves this slice without it
    assert_give_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (give && !take) |=> !held);

    // R3 and R4: a take pulse always lands
    assert_take_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> held);

endmodule

// File: rtl/dxc_slice.sv
module dxc_slice
    import dxc_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] wdata,
    input  hop_t             xin,
    output hop_t             xout,
    output logic [WIDTH-1:0] q,
    output logic             q_oe,
    output logic             full_n,
    output logic             empty_n,
    output logic             wtok,
    output logic             rtok
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic             wr_go, rd_go, wr_last, rd_last;

    always_comb begin
        wr_go   = wr_en && wtok && (cnt != CAP);
        rd_go   = rd_en && rtok && (cnt != '0);
        wr_last = wr_go && (wptr == LAST);
        rd_last = rd_go && (rptr == LAST);
        xout.wr = wr_last;
        xout.rd = rd_last;
    end

    dxc_token u_wtok (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_n (first_n),
        .take    (xin.wr),
        .give    (wr_last),
        .held    (wtok)
    );

    dxc_token u_rtok (
        .clk     (clk),
        .rst_n   (rst_n),
        .first_n (first_n),
        .take    (xin.rd),
        .give    (rd_last),
        .held    (rtok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_go) wptr <= wr_last ? '0 : wptr + 1'b1;
            if (rd_go) rptr <= rd_last ? '0 : rptr + 1'b1;
            unique case ({wr_go, rd_go})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[wptr] <= wdata;
    end

    always_comb begin
        q       = mem[rptr];
        q_oe    = rtok;
        full_n  = (cnt != CAP);
        empty_n = (cnt != '0);
    end

    // R6: occupancy never exceeds the slice depth
    assert_cnt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);

    // R3: after a write hand-off the write pointer restarts at location 0
    assert_wr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xout.wr |=> (wptr == '0));

    // R4: after a read hand-off the read pointer restarts at location 0
    assert_rd_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xout.rd |=> (rptr == '0));

    // R6: a full slice without a read stays full
    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_en) |=> !full_n);

endmodule

// File: rtl/dx_fifo_chain.sv
module dx_fifo_chain
    import dxc_pkg::*;
#(
    parameter int NSLICE = 3,
    parameter int DEPTH  = 4,
    parameter int WIDTH  = 9,
    localparam int SELW  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SELW-1:0]   first_slice,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rdata,
    output logic              full_n,
    output logic              empty_n,
    output logic [NSLICE-1:0] link_wr,
    output logic [NSLICE-1:0] link_rd
);

    hop_t                         hop_v   [NSLICE];
    logic [NSLICE-1:0][WIDTH-1:0] q_v;
    logic [NSLICE-1:0]            oe_v, full_v, empty_v, wtok_v, rtok_v;

    for (genvar gi = 0; gi < NSLICE; gi++) begin : g_slice
        localparam int PREV = (gi + NSLICE - 1) % NSLICE;

        dxc_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .first_n (first_slice != SELW'(gi)),
            .wr_en   (wr_en),
            .rd_en   (rd_en),
            .wdata   (wdata),
            .xin     (hop_v[PREV]),
            .xout    (hop_v[gi]),
            .q       (q_v[gi]),
            .q_oe    (oe_v[gi]),
            .full_n  (full_v[gi]),
            .empty_n (empty_v[gi]),
            .wtok    (wtok_v[gi]),
            .rtok    (rtok_v[gi])
        );

        assign link_wr[gi] = hop_v[gi].wr;
        assign link_rd[gi] = hop_v[gi].rd;
    end

    // Only the read-token holder puts its word on the shared output.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLICE; i++) begin
            if (oe_v[i]) rdata = rdata | q_v[i];
        end
    end

    // Active-low flags: composite is asserted only when all slices agree.
    always_comb begin
        full_n  = |full_v;
        empty_n = |empty_v;
    end

    // R9: one write-token holder and one read-token holder
    assert_one_wtok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wtok_v) == 1);
    assert_one_rtok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rtok_v) == 1);

    // R3 / R4: at most one hand-off of each kind per cycle
    assert_link_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_wr));
    assert_link_rd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_rd));

    // R7: an empty chain with no push stays empty
    assert_empty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_en) |=> !empty_n);

    // R6: a full chain with no pop stays full
    assert_full_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_en) |=> !full_n);

endmodule

// File: tb/tb_dx_fifo_chain.sv
module tb_dx_fifo_chain;

    localparam int N   = 3;
    localparam int D   = 4;
    localparam int W   = 9;
    localparam int CAP = N * D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   first_slice = 2'd0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         full_n, empty_n;
    logic [N-1:0] link_wr, link_rd;

    always #4 clk = ~clk;

    dx_fifo_chain #(.NSLICE(N), .DEPTH(D), .WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .first_slice(first_slice),
        .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
        .full_n(full_n), .empty_n(empty_n), .link_wr(link_wr), .link_rd(link_rd)
    );

    int           checks = 0, fails = 0;
    bit           done = 1'b0;
    logic [W-1:0] mq[$];
    int           wslc, wloc, rslc, rloc;
    bit           both_prev, lap0w, lap0r;

    function automatic logic [N-1:0] hop_mask(bit fire, int slc);
        return fire ? (N'(1) << slc) : '0;
    endfunction

    function automatic logic exp_full_n(int c);
        return (c == CAP) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic exp_empty_n(int c);
        return (c == 0) ? 1'b0 : 1'b1;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(int fs);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; first_slice = 2'(fs);
        repeat (2) @(negedge clk);
        #1;
        chk(empty_n == 1'b0, "R1 empty in reset", 32'(empty_n), 0);
        chk(full_n == 1'b1, "R1 full in reset", 32'(full_n), 1);
        rst_n = 1'b1;
        mq.delete();
        wslc = fs; rslc = fs; wloc = 0; rloc = 0;
        both_prev = 1'b0; lap0w = 1'b1; lap0r = 1'b1;
        #1;
        chk(empty_n == 1'b0, "R1 empty after reset", 32'(empty_n), 0);
        chk(full_n == 1'b1, "R1 full after reset", 32'(full_n), 1);
        chk(link_wr == '0 && link_rd == '0, "R1 links idle",
            32'({link_wr, link_rd}), 0);
    endtask

    // Drive one cycle's strobes, check before the edge, then advance the model.
    task automatic step(bit we, logic [W-1:0] d, bit re);
        int  cnt;
        bit  wa, ra;
        logic [N-1:0] ew, er;
        wr_en = we; wdata = d; rd_en = re;
        #1;
        cnt = mq.size();
        wa  = we && (cnt < CAP);
        ra  = re && (cnt > 0);
        chk(full_n == exp_full_n(cnt), both_prev ? "R8 full flag" : "R6 full flag",
            32'(full_n), 32'(exp_full_n(cnt)));
        chk(empty_n == exp_empty_n(cnt), both_prev ? "R8 empty flag" : "R7 empty flag",
            32'(empty_n), 32'(exp_empty_n(cnt)));
        if (cnt > 0)
            chk(rdata == mq[0], both_prev ? "R8 head word" : "R2 head word",
                32'(rdata), 32'(mq[0]));
        ew = hop_mask(wa && (wloc == D - 1), wslc);
        er = hop_mask(ra && (rloc == D - 1), rslc);
        chk(link_wr == ew, lap0w ? "R5 first write hand-off" : "R3 write hand-off",
            32'(link_wr), 32'(ew));
        chk(link_rd == er, lap0r ? "R5 first read hand-off" : "R4 read hand-off",
            32'(link_rd), 32'(er));
        @(posedge clk);
        if (ra) begin
            void'(mq.pop_front());
            if (rloc == D - 1) begin rloc = 0; rslc = (rslc + 1) % N; lap0r = 1'b0; end
            else rloc++;
        end
        if (wa) begin
            mq.push_back(d);
            if (wloc == D - 1) begin wloc = 0; wslc = (wslc + 1) % N; lap0w = 1'b0; end
            else wloc++;
        end
        both_prev = wa && ra;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int k = 0; k < CAP + 1; k++) step(1'b0, '0, 1'b1);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        // R1, R3, R4, R2: fill and drain from slice 0
        do_reset(0);
        for (int k = 0; k < CAP; k++) step(1'b1, W'(k * 37 + 5), 1'b0);
        // R6: write attempted while full is dropped
        step(1'b1, 9'h1FF, 1'b0);
        step(1'b1, 9'h1FE, 1'b0);
        drain();               // R7: the last step is a read while empty
        step(1'b0, '0, 1'b1);
        // R8: push and pop together across a write hand-off
        for (int k = 0; k < D + 1; k++) step(1'b1, W'(k + 100), 1'b0);
        for (int k = 0; k < D; k++) step(1'b1, W'(k + 200), 1'b1);
        drain();
        // R8: push and pop together while full and while empty
        for (int k = 0; k < CAP; k++) step(1'b1, W'(k + 300), 1'b0);
        step(1'b1, 9'h0AA, 1'b1);
        drain();
        step(1'b1, 9'h055, 1'b1);
        drain();
        // R5: start the ring at slice 2
        do_reset(2);
        for (int k = 0; k < CAP; k++) step(1'b1, W'($urandom % 512), 1'b0);
        drain();
        do_reset(1);
        // Random phases with shifting push/pop bias
        for (int ph = 0; ph < 12; ph++) begin
            int pw = (ph % 3 == 0) ? 80 : ((ph % 3 == 1) ? 50 : 25);
            for (int k = 0; k < 250; k++)
                step(($urandom % 100) < pw, W'($urandom % 512), ($urandom % 100) < (100 - pw + 5));
        end
        drain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog expired act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule